// File: doc/BRIEF.md
# Shadowed RAM Control Decoder

This block is the control front end of a byte-wide memory whose volatile RAM is backed bit-for-bit by a nonvolatile array. Once per clock it registers four active-low strobes (chip select, output enable, write enable and nonvolatile select), a supply-good input and the busy flag of the transfer engine. From these it decodes one of eight operating modes. It drives the data-bus output enable and the RAM write enable. It also issues single-cycle requests that tell the transfer engine to copy the whole RAM into the nonvolatile array (store) or to copy the array back into the RAM (recall).

Store and recall are started by holding a strobe combination on the control lines. The combination must stay stable for `QUAL_CYCLES` consecutive clocks before anything happens, so short glitches are filtered out. Each held combination produces at most one request. A store is accepted only after a RAM write has taken place, and it is blocked whenever output enable is low. Everything is held off while the supply is not good, and new RAM accesses and new requests are held off while the engine is busy.

Top module: `nvShadowCtrl`

## Requirements
- R1: One clock after the strobes are presented, `opMode` reports the decoded mode. With chip select high the mode is 0 (not selected), whatever the other strobes are. With chip select low the mode is taken from output enable, write enable and nonvolatile select (0 means low, 1 means high):
  - 0, 1, 1 gives 1 (RAM read).
  - 1, 0, 1 gives 2 (RAM write).
  - 0, 1, 0 gives 3 (recall).
  - 1, 0, 0 gives 4 (store).
  - 1, 1, 1 gives 5 (output disabled).
  - 0, 0, 0 gives 7 (disallowed).
  - 0, 0, 1 and 1, 1, 0 give 6 (no operation).
- R2: `busDriveEn` is high only in mode 1 while supply is good and the engine is not busy. In every other mode, including any mode where nonvolatile select is low, the bus is released.
- R3: `ramWriteEn` is high only in mode 2 while supply is good and the engine is not busy.
- R4: Mode 3 held for `QUAL_CYCLES` consecutive clocks produces exactly one single-cycle `recallReq` pulse. A hold that is one clock shorter produces none.
- R5: Mode 4 held for `QUAL_CYCLES` clocks produces one single-cycle `storeReq` pulse, but only if a RAM write has been accepted since reset or since the last store request. Otherwise no store request is issued.
- R6: Only one request is issued per held combination, however long it is held. A new request needs the combination to be released and presented again. `storeReq` and `recallReq` are never high together.
- R7: Mode 7, and any combination with output enable low, never produces a store request.
- R8: While `supplyOk` is low there is no bus drive, no RAM write and no request.
- R9: While `engineBusy` is high there is no bus drive, no RAM write and no request.
- R10: After reset every output is low, `opMode` is 0 and no RAM write is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| supplyOk | input | 1 | Supply good indication |
| ceN | input | 1 | Chip select, active low |
| oeN | input | 1 | Output enable, active low |
| weN | input | 1 | Write enable, active low |
| nvN | input | 1 | Nonvolatile select, active low |
| engineBusy | input | 1 | Transfer engine busy |
| opMode | output | 3 | Decoded mode code (R1) |
| busDriveEn | output | 1 | Data bus output enable |
| ramWriteEn | output | 1 | RAM write enable |
| storeReq | output | 1 | Single-cycle store request |
| recallReq | output | 1 | Single-cycle recall request |

## Verification
The assertions check, on every cycle, the following properties:
- The bus drive and the write enable only ever accompany the read and write modes.
- A request is always one cycle long, matches the mode that was held the cycle before, and never follows a busy or a supply-off sample.
- Store and recall requests never coincide.

Some behaviours depend on how long a combination is held and on what happened before, and only the bench scenarios can show them:
- The exact hold length that qualifies a request.
- One pulse per long hold.
- Re-arming after release.
- The need for a fresh RAM write before each store.

// File: rtl/nvsc_pkg.sv
package nvsc_pkg;
  typedef enum logic [2:0] {
    MODE_IDLE    = 3'd0,
    MODE_READ    = 3'd1,
    MODE_WRITE   = 3'd2,
    MODE_RECALL  = 3'd3,
    MODE_STORE   = 3'd4,
    MODE_OUTOFF  = 3'd5,
    MODE_NOOP    = 3'd6,
    MODE_BLOCKED = 3'd7
  } opMode_e;

  // decoded strobes handed from the datapath to the sequencer
  typedef struct packed {
    logic okGate;
    logic writeSel;
    logic recallSel;
    logic storeSel;
  } decStrobes_t;
endpackage

// File: rtl/nvscDecode.sv
module nvscDecode
  import nvsc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        supplyOk,
  input  logic        ceN,
  input  logic        oeN,
  input  logic        weN,
  input  logic        nvN,
  input  logic        engineBusy,
  output opMode_e     mode,
  output decStrobes_t strobes,
  output logic        busDriveEn,
  output logic        ramWriteEn
);
  logic ceS, oeS, weS, nvS, okS, busyS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ceS   <= 1'b1;
      oeS   <= 1'b1;
      weS   <= 1'b1;
      nvS   <= 1'b1;
      okS   <= 1'b0;
      busyS <= 1'b0;
    end else begin
      ceS   <= ceN;
      oeS   <= oeN;
      weS   <= weN;
      nvS   <= nvN;
      okS   <= supplyOk;
      busyS <= engineBusy;
    end
  end

  always_comb begin
    if (ceS) begin
      mode = MODE_IDLE;
    end else begin
      unique case ({oeS, weS, nvS})
        3'b011:  mode = MODE_READ;
        3'b101:  mode = MODE_WRITE;
        3'b010:  mode = MODE_RECALL;
        3'b100:  mode = MODE_STORE;
        3'b111:  mode = MODE_OUTOFF;
        3'b000:  mode = MODE_BLOCKED;
        default: mode = MODE_NOOP;
      endcase
    end
  end

  logic gate;
  assign gate = okS && !busyS;

  always_comb begin
    strobes.okGate    = gate;
    strobes.writeSel  = (mode == MODE_WRITE);
    strobes.recallSel = (mode == MODE_RECALL);
    strobes.storeSel  = (mode == MODE_STORE);
  end

  assign busDriveEn = gate && (mode == MODE_READ);
  assign ramWriteEn = gate && (mode == MODE_WRITE);
endmodule

// File: rtl/nvscSeq.sv
module nvscSeq
  import nvsc_pkg::*;
#(
  parameter int QUAL_CYCLES = 5
) (
  input  logic        clk,
  input  logic        rstN,
  input  decStrobes_t strobes,
  output logic        storeReq,
  output logic        recallReq
);
  localparam int CNT_W = (QUAL_CYCLES < 2) ? 1 : $clog2(QUAL_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(QUAL_CYCLES - 1);

  logic [CNT_W-1:0] holdCnt;
  logic fired, writeSeen, lastHeld, lastStore;
  logic holdNv, kindFlip, reachNow;

  assign holdNv   = strobes.recallSel || strobes.storeSel;
  assign kindFlip = holdNv && lastHeld && (strobes.storeSel != lastStore);
  assign reachNow = strobes.okGate && (holdCnt == CNT_LAST) && !fired;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt   <= '0;
      fired     <= 1'b0;
      writeSeen <= 1'b0;
      lastHeld  <= 1'b0;
      lastStore <= 1'b0;
      storeReq  <= 1'b0;
      recallReq <= 1'b0;
    end else begin
      storeReq  <= 1'b0;
      recallReq <= 1'b0;
      lastHeld  <= holdNv;
      lastStore <= strobes.storeSel;
      if (strobes.okGate && strobes.writeSel) writeSeen <= 1'b1;
      if (!holdNv) begin
        holdCnt <= '0;
        fired   <= 1'b0;
      end else if (kindFlip) begin
        holdCnt <= '0;
        fired   <= 1'b0;
      end else if (!strobes.okGate) begin
        holdCnt <= '0;
      end else if (reachNow) begin
        fired <= 1'b1;
        if (strobes.recallSel) begin
          recallReq <= 1'b1;
        end else if (writeSeen) begin
          storeReq  <= 1'b1;
          writeSeen <= 1'b0;
        end
      end else if (holdCnt != CNT_LAST) begin
        holdCnt <= holdCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/nvShadowCtrl.sv
module nvShadowCtrl
  import nvsc_pkg::*;
#(
  parameter int QUAL_CYCLES = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       supplyOk,
  input  logic       ceN,
  input  logic       oeN,
  input  logic       weN,
  input  logic       nvN,
  input  logic       engineBusy,
  output logic [2:0] opMode,
  output logic       busDriveEn,
  output logic       ramWriteEn,
  output logic       storeReq,
  output logic       recallReq
);
  opMode_e     modeDec;
  decStrobes_t strobes;

  nvscDecode u_decode (
    .clk(clk), .rstN(rstN), .supplyOk(supplyOk),
    .ceN(ceN), .oeN(oeN), .weN(weN), .nvN(nvN),
    .engineBusy(engineBusy), .mode(modeDec), .strobes(strobes),
    .busDriveEn(busDriveEn), .ramWriteEn(ramWriteEn)
  );

  nvscSeq #(.QUAL_CYCLES(QUAL_CYCLES)) u_seq (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .storeReq(storeReq), .recallReq(recallReq)
  );

  assign opMode = modeDec;
endmodule

// File: rtl/nvShadowCtrl_chk.sv
module nvShadowCtrl_chk (
  input logic       clk,
  input logic       rstN,
  input logic       supplyOk,
  input logic       engineBusy,
  input logic [2:0] opMode,
  input logic       busDriveEn,
  input logic       ramWriteEn,
  input logic       storeReq,
  input logic       recallReq
);
  AST_BUS_READ_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    busDriveEn |-> opMode == 3'd1); // R2
  AST_WRITE_MODE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    ramWriteEn |-> opMode == 3'd2); // R3
  AST_RECALL_FROM_MODE: assert property (@(posedge clk) disable iff (!rstN)
    recallReq |-> $past(opMode) == 3'd3); // R4
  AST_STORE_FROM_MODE: assert property (@(posedge clk) disable iff (!rstN)
    storeReq |-> $past(opMode) == 3'd4); // R5
  AST_STORE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    storeReq |=> !storeReq); // R6
  AST_RECALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    recallReq |=> !recallReq); // R6
  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(storeReq && recallReq)); // R6
  AST_BUS_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (!rstN)
    (busDriveEn || ramWriteEn) |-> $past(supplyOk)); // R8
  AST_REQ_NEEDS_IDLE_ENGINE: assert property (@(posedge clk) disable iff (!rstN)
    (storeReq || recallReq) |-> !$past(engineBusy, 2) && $past(supplyOk, 2)); // R9
endmodule

bind nvShadowCtrl nvShadowCtrl_chk u_chk (
  .clk(clk), .rstN(rstN), .supplyOk(supplyOk), .engineBusy(engineBusy),
  .opMode(opMode), .busDriveEn(busDriveEn), .ramWriteEn(ramWriteEn),
  .storeReq(storeReq), .recallReq(recallReq)
);

// File: tb/nvShadowCtrl_bench.sv
`timescale 1ns/1ps
module nvShadowCtrl_bench;
  localparam int QUAL = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic supplyOk = 1'b1;
  logic ceN = 1'b1, oeN = 1'b1, weN = 1'b1, nvN = 1'b1;
  logic engineBusy = 1'b0;
  logic [2:0] opMode;
  logic busDriveEn, ramWriteEn, storeReq, recallReq;

  int checks = 0;
  int fails = 0;
  int storeCnt = 0;
  int recallCnt = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  nvShadowCtrl #(.QUAL_CYCLES(QUAL)) u_nvShadowCtrl (
    .clk(clk), .rstN(rstN), .supplyOk(supplyOk),
    .ceN(ceN), .oeN(oeN), .weN(weN), .nvN(nvN), .engineBusy(engineBusy),
    .opMode(opMode), .busDriveEn(busDriveEn), .ramWriteEn(ramWriteEn),
    .storeReq(storeReq), .recallReq(recallReq)
  );

  always @(negedge clk) begin
    if (storeReq) storeCnt++;
    if (recallReq) recallCnt++;
  end

  // {ceN, oeN, weN, nvN, mode[2:0], bus, wr}
  localparam int NV = 11;
  localparam logic [8:0] VEC [NV] = '{
    {4'b1111, 3'd0, 1'b0, 1'b0},
    {4'b0011, 3'd1, 1'b1, 1'b0},
    {4'b0101, 3'd2, 1'b0, 1'b1},
    {4'b0111, 3'd5, 1'b0, 1'b0},
    {4'b0001, 3'd6, 1'b0, 1'b0},
    {4'b0010, 3'd3, 1'b0, 1'b0},
    {4'b0100, 3'd4, 1'b0, 1'b0},
    {4'b0000, 3'd7, 1'b0, 1'b0},
    {4'b0110, 3'd6, 1'b0, 1'b0},
    {4'b1000, 3'd0, 1'b0, 1'b0},
    {4'b1010, 3'd0, 1'b0, 1'b0}
  };

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(logic [3:0] s);
    {ceN, oeN, weN, nvN} = s;
  endtask

  // hold a combination for n cycles, release, then settle
  task automatic hold(logic [3:0] s, int n);
    drive(s);
    repeat (n) @(negedge clk);
    drive(4'b1111);
    repeat (3) @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    drive(4'b1111);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    int s0, r0;
    repeat (2) @(negedge clk);
    // R10 reset state
    check("R10 opMode", opMode, 0);
    check("R10 outputs", {busDriveEn, ramWriteEn, storeReq, recallReq}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 R2 R3 decode table
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][8:5]);
      @(negedge clk);
      check("R1 mode", opMode, VEC[i][4:2]);
      check("R2 bus", busDriveEn, VEC[i][1]);
      check("R3 write", ramWriteEn, VEC[i][0]);
    end
    drive(4'b1111);
    repeat (2) @(negedge clk);

    // R4 recall qualification
    r0 = recallCnt;
    hold(4'b0010, QUAL - 1);
    check("R4 short recall", recallCnt - r0, 0);
    r0 = recallCnt;
    hold(4'b0010, QUAL);
    check("R4 qualified recall", recallCnt - r0, 1);
    // R6 long hold gives one pulse, re-arm after release
    r0 = recallCnt;
    hold(4'b0010, 4 * QUAL);
    check("R6 long hold", recallCnt - r0, 1);
    r0 = recallCnt;
    hold(4'b0010, QUAL);
    check("R6 re-arm", recallCnt - r0, 1);

    // R5 store needs a prior write
    doReset();
    s0 = storeCnt;
    hold(4'b0100, 2 * QUAL);
    check("R5 store without write", storeCnt - s0, 0);
    hold(4'b0101, 1);
    s0 = storeCnt;
    hold(4'b0100, QUAL - 1);
    check("R5 short store", storeCnt - s0, 0);
    s0 = storeCnt;
    hold(4'b0100, QUAL);
    check("R5 armed store", storeCnt - s0, 1);
    s0 = storeCnt;
    hold(4'b0100, 2 * QUAL);
    check("R5 store consumes arm", storeCnt - s0, 0);

    // R7 disallowed and output-enable-low combinations
    hold(4'b0101, 1);
    s0 = storeCnt; r0 = recallCnt;
    drive(4'b0000);
    @(negedge clk);
    check("R7 blocked code", opMode, 7);
    repeat (2 * QUAL) @(negedge clk);
    drive(4'b1111);
    repeat (3) @(negedge clk);
    check("R7 no store", storeCnt - s0, 0);
    check("R7 no recall", recallCnt - r0, 0);
    s0 = storeCnt;
    hold(4'b0001, 2 * QUAL);
    check("R7 oe low no store", storeCnt - s0, 0);
    s0 = storeCnt;
    hold(4'b0100, QUAL);
    check("R7 arm kept", storeCnt - s0, 1);

    // R8 supply off
    supplyOk = 1'b0;
    @(negedge clk);
    drive(4'b0011);
    @(negedge clk);
    check("R8 no bus", busDriveEn, 0);
    drive(4'b0101);
    @(negedge clk);
    check("R8 no write", ramWriteEn, 0);
    r0 = recallCnt;
    hold(4'b0010, 2 * QUAL);
    check("R8 no recall", recallCnt - r0, 0);
    supplyOk = 1'b1;
    @(negedge clk);

    // R9 engine busy
    engineBusy = 1'b1;
    @(negedge clk);
    drive(4'b0011);
    @(negedge clk);
    check("R9 no bus", busDriveEn, 0);
    drive(4'b0101);
    @(negedge clk);
    check("R9 no write", ramWriteEn, 0);
    r0 = recallCnt;
    hold(4'b0010, 2 * QUAL);
    check("R9 no recall", recallCnt - r0, 0);
    engineBusy = 1'b0;
    @(negedge clk);
    drive(4'b0011);
    @(negedge clk);
    check("R2 bus after busy", busDriveEn, 1);
    drive(4'b1111);
    @(negedge clk);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule